// File: doc/BRIEF.md
# Multi-Order Pseudo-Random Pattern Lane Checker

This block checks one receive lane of a serial link against a pseudo-random binary sequence (PRBS). Each clock it may take one 32-bit parallel word from the lane, marked by a valid strobe. Bit 0 of each word is the earliest bit in time. A three-bit select picks one of five maximal-length polynomials. The checker needs no seed from outside: it fills its shift history from the received bits and then acquires lock on its own. After lock it runs free and compares every received bit against its own prediction.

Two registered results come out. The first is a saturating error counter. The second is a three-bit status word:
- bit 0 means the lane arrives complemented (polarity swapped).
- bit 1 means no lock yet, so the incoming data is not recognisable.
- bit 2 is a sticky flag meaning at least one bit error has been counted.

A clear input starts a new measurement window. Changing the polynomial select throws away the current lock, and the checker acquires again.

A complemented lane is told apart from a noisy lane. The checker counts consecutive mismatches as well as consecutive matches. A long run of mismatches means inversion, not errors. After lock the checker keeps checking with the polarity it found.

Top module: `prbs_lane_checker`

## Requirements
- R1: After reset the error count is 0 and the status word is 3'b010: locked=no, inverted=no, error=no.
- R2: The select encodings are 0=PRBS7 (x^7+x^6+1), 1=PRBS9 (x^9+x^5+1), 2=PRBS15 (x^15+x^14+1), 3=PRBS23 (x^23+x^18+1), 4=PRBS31 (x^31+x^28+1); codes 5..7 act as PRBS31. For these polynomials, bit b[n] = b[n-A] xor b[n-B], where A and B are the two exponents. Word bit 0 is the earliest bit. A clean stream for each order ends with status 3'b000 and count 0.
- R3: Acquisition works in two steps. The first N bits, where N is the order, only fill the history. Lock comes after 64 consecutive bits that all match the prediction, or 64 consecutive bits that all mismatch it. A word with valid low is ignored.
- R4: Once locked, each received bit that differs from the prediction adds exactly one to the count and sets status bit 2. A bad bit does not disturb later predictions.
- R5: A lane that locks through the mismatch run sets status bit 0. It then checks the complemented data, so a clean inverted lane keeps count 0 and status bit 2 clear.
- R6: While the checker is not locked, status bit 1 stays 1 and the count does not change. Non-pattern data keeps the checker in this state.
- R7: The count saturates at all ones and does not wrap.
- R8: A clear zeroes the count and status bit 2. Status bits 0 and 1 are left alone. Errors in a word accepted in the same cycle as a clear are counted on top of zero.
- R9: A change of the select drops lock, and status bit 1 is 1 after that edge. The word presented in that cycle is discarded, and acquisition restarts with the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Polynomial order select |
| valid_i | input | 1 | Lane word valid |
| data_i | input | DATA_W | Lane word, bit 0 earliest in time |
| clr_i | input | 1 | Clear count and error flag |
| err_count_o | output | CNT_W | Saturating bit error count |
| status_o | output | 3 | {bit error, not locked, inverted} |

## Verification
Two events can fall in the same cycle: a clear and the arrival of a word that carries bit errors. The bench provokes this by asserting the clear on the same edge that accepts a locked word with three flipped bits. The count afterwards must be exactly 3, with the error flag set, rather than 0 or the old total plus 3. It also combines saturation with a clear, and a select change with a valid word in the same cycle. In the second case the word must leave no trace once the checker relocks.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int MAX_ORDER = 31;

  typedef enum logic [1:0] {
    PH_FILL = 2'd0,
    PH_HUNT = 2'd1,
    PH_LOCK = 2'd2
  } phase_e;

  typedef struct packed {
    logic [4:0] order;
    logic [4:0] tap_a;
    logic [4:0] tap_b;
  } poly_t;

  function automatic poly_t poly_of(input logic [2:0] sel);
    poly_t p;
    case (sel)
      3'd0:    p = '{order: 5'd7,  tap_a: 5'd7,  tap_b: 5'd6};
      3'd1:    p = '{order: 5'd9,  tap_a: 5'd9,  tap_b: 5'd5};
      3'd2:    p = '{order: 5'd15, tap_a: 5'd15, tap_b: 5'd14};
      3'd3:    p = '{order: 5'd23, tap_a: 5'd23, tap_b: 5'd18};
      default: p = '{order: 5'd31, tap_a: 5'd31, tap_b: 5'd28};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/prbs_word_engine.sv
module prbs_word_engine
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LOCK_RUN = 64,
  localparam int RUN_W   = $clog2(LOCK_RUN + 1),
  localparam int ERR_W   = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0]    data,
  input  poly_t                poly,
  input  phase_e               ph_q,
  input  logic [4:0]           fill_q,
  input  logic [RUN_W-1:0]     run_eq_q,
  input  logic [RUN_W-1:0]     run_ne_q,
  input  logic                 inv_q,
  input  logic [MAX_ORDER-1:0] hist_q,
  output phase_e               ph_d,
  output logic [4:0]           fill_d,
  output logic [RUN_W-1:0]     run_eq_d,
  output logic [RUN_W-1:0]     run_ne_d,
  output logic                 inv_d,
  output logic [MAX_ORDER-1:0] hist_d,
  output logic [ERR_W-1:0]     nerr
);

  always_comb begin
    phase_e               ph;
    logic [4:0]           fc;
    logic [RUN_W-1:0]     req, rne;
    logic                 inv;
    logic [MAX_ORDER-1:0] h;
    logic [ERR_W-1:0]     ec;
    logic                 r, p, e;
    ph  = ph_q;
    fc  = fill_q;
    req = run_eq_q;
    rne = run_ne_q;
    inv = inv_q;
    h   = hist_q;
    ec  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      r = data[i];
      p = h[poly.tap_a - 5'd1] ^ h[poly.tap_b - 5'd1];
      e = p ^ inv;
      case (ph)
        PH_FILL: begin
          h  = {h[MAX_ORDER-2:0], r};
          fc = fc + 5'd1;
          if (fc == poly.order) begin
            ph  = PH_HUNT;
            req = '0;
            rne = '0;
          end
        end
        PH_HUNT: begin
          h = {h[MAX_ORDER-2:0], r};
          if (r == p) begin
            req = req + 1'b1;
            rne = '0;
          end else begin
            rne = rne + 1'b1;
            req = '0;
          end
          if (req == RUN_W'(LOCK_RUN)) begin
            ph  = PH_LOCK;
            inv = 1'b0;
          end else if (rne == RUN_W'(LOCK_RUN)) begin
            ph  = PH_LOCK;
            inv = 1'b1;
          end
        end
        default: begin
          if (r != e) ec = ec + 1'b1;
          h = {h[MAX_ORDER-2:0], e};
        end
      endcase
    end
    ph_d     = ph;
    fill_d   = fc;
    run_eq_d = req;
    run_ne_d = rne;
    inv_d    = inv;
    hist_d   = h;
    nerr     = ec;
  end

endmodule

// File: rtl/prbs_err_accum.sv
module prbs_err_accum #(
  parameter int CNT_W = 32,
  parameter int ADD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [ADD_W-1:0] add,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);

  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;

  always_comb begin
    base = clr ? '0 : cnt;
    sum  = {1'b0, base} + (CNT_W+1)'(add);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      flag <= (flag & ~clr) | (add != '0);
    end
  end

endmodule

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int LOCK_RUN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  err_count_o,
  output logic [2:0]        status_o
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int ERR_W = $clog2(DATA_W + 1);

  logic [2:0]           sel_q;
  phase_e               ph_q, ph_d;
  logic [4:0]           fill_q, fill_d;
  logic [RUN_W-1:0]     req_q, req_d, rne_q, rne_d;
  logic                 inv_q, inv_d;
  logic [MAX_ORDER-1:0] hist_q, hist_d;
  logic [ERR_W-1:0]     nerr;
  logic                 restart, take;
  logic                 err_flag;

  assign restart = (sel_i != sel_q);
  assign take    = valid_i && !restart;

  prbs_word_engine #(.DATA_W(DATA_W), .LOCK_RUN(LOCK_RUN)) u_eng (
    .data     (data_i),
    .poly     (poly_of(sel_q)),
    .ph_q     (ph_q),
    .fill_q   (fill_q),
    .run_eq_q (req_q),
    .run_ne_q (rne_q),
    .inv_q    (inv_q),
    .hist_q   (hist_q),
    .ph_d     (ph_d),
    .fill_d   (fill_d),
    .run_eq_d (req_d),
    .run_ne_d (rne_d),
    .inv_d    (inv_d),
    .hist_d   (hist_d),
    .nerr     (nerr)
  );

  prbs_err_accum #(.CNT_W(CNT_W), .ADD_W(ERR_W)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_i),
    .add  (take ? nerr : '0),
    .cnt  (err_count_o),
    .flag (err_flag)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sel_q  <= sel_i;
      ph_q   <= PH_FILL;
      fill_q <= '0;
      req_q  <= '0;
      rne_q  <= '0;
      inv_q  <= 1'b0;
      hist_q <= '0;
    end else if (take) begin
      ph_q   <= ph_d;
      fill_q <= fill_d;
      req_q  <= req_d;
      rne_q  <= rne_d;
      inv_q  <= inv_d;
      hist_q <= hist_d;
    end
  end

  assign status_o = {err_flag, ph_q != PH_LOCK, inv_q};

endmodule

// File: rtl/prbs_lane_checker_sva.sv
module prbs_lane_checker_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       sel_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] err_count_o,
  input logic [2:0]       status_o
);

  // R4: the count only moves down through a clear
  a_r4_count_monotone: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_i) |-> err_count_o >= $past(err_count_o));

  // R7: once at all ones, the count stays there until a clear
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    ($past(err_count_o) == '1 && !$past(clr_i)) |-> err_count_o == '1);

  // R4: a rise in the count comes with the error flag
  a_r4_flag_with_count: assert property (@(posedge clk) disable iff (rst)
    (err_count_o > $past(err_count_o)) |-> status_o[2]);

  // R6: no counting while unlocked
  a_r6_hold_unlocked: assert property (@(posedge clk) disable iff (rst)
    (status_o[1] && !$past(clr_i)) |-> $stable(err_count_o));

  // R9: a select change drops lock
  a_r9_sel_unlock: assert property (@(posedge clk) disable iff (rst)
    (sel_i != $past(sel_i)) |=> status_o[1]);

endmodule

bind prbs_lane_checker prbs_lane_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .sel_i       (sel_i),
  .clr_i       (clr_i),
  .err_count_o (err_count_o),
  .status_o    (status_o)
);

// File: tb/sim_prbs_lane_checker.sv
module sim_prbs_lane_checker;

  localparam int DW = 32;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    sel = 3'd0;
  logic          valid = 1'b0;
  logic [DW-1:0] data = '0;
  logic          clr = 1'b0;
  logic [CW-1:0] cnt;
  logic [2:0]    st;

  int n_chk = 0;
  int n_bad = 0;
  logic [30:0] g_h;
  int g_a, g_b;
  logic [31:0] lcg;

  always #10 clk = ~clk;

  prbs_lane_checker #(.DATA_W(DW), .CNT_W(CW), .LOCK_RUN(64)) u0 (
    .clk(clk), .rst(rst), .sel_i(sel), .valid_i(valid), .data_i(data),
    .clr_i(clr), .err_count_o(cnt), .status_o(st)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic gen_init(input logic [2:0] s);
    case (s)
      3'd0: begin g_a = 7;  g_b = 6;  end
      3'd1: begin g_a = 9;  g_b = 5;  end
      3'd2: begin g_a = 15; g_b = 14; end
      3'd3: begin g_a = 23; g_b = 18; end
      default: begin g_a = 31; g_b = 28; end
    endcase
    g_h = 31'h5A5A5A5B;
  endtask

  function automatic logic [DW-1:0] gen_word();
    logic [DW-1:0] w;
    logic b;
    for (int i = 0; i < DW; i++) begin
      b = g_h[g_a-1] ^ g_h[g_b-1];
      g_h = {g_h[29:0], b};
      w[i] = b;
    end
    return w;
  endfunction

  // drive at negedge, the edge between takes it, sample at next negedge
  task automatic put(input logic v, input logic [DW-1:0] w, input logic c);
    valid = v; data = w; clr = c;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", cnt, 0);
    check("R1 status", st, 3'b010);
  endtask

  task automatic t_orders();
    for (int s = 0; s < 6; s++) begin
      sel = 3'(s);
      put(1'b0, '0, 1'b1);
      gen_init(3'(s));
      for (int k = 0; k < 4; k++) put(1'b1, gen_word(), 1'b0);
      check($sformatf("R2 status sel%0d", s), st, 3'b000);
      check($sformatf("R2 count sel%0d", s), cnt, 0);
    end
  endtask

  task automatic t_lock_timing();
    sel = 3'd1;
    put(1'b0, '0, 1'b0);
    sel = 3'd0;
    put(1'b0, '0, 1'b0);
    gen_init(3'd0);
    put(1'b1, gen_word(), 1'b0);
    put(1'b0, 32'hFFFF0000, 1'b0);
    put(1'b1, gen_word(), 1'b0);
    check("R3 unlocked after 64 bits", st[1], 1);
    put(1'b1, gen_word(), 1'b0);
    check("R3 locked after 96 bits", st, 3'b000);
  endtask

  task automatic t_errors();
    logic [DW-1:0] w;
    put(1'b0, '0, 1'b1);
    w = gen_word() ^ 32'h8000_0021;
    put(1'b1, w, 1'b0);
    check("R4 count 3", cnt, 3);
    check("R4 flag", st, 3'b100);
    put(1'b1, gen_word(), 1'b0);
    put(1'b1, gen_word(), 1'b0);
    check("R4 no propagation", cnt, 3);
  endtask

  task automatic t_clear_same_cycle();
    put(1'b1, gen_word() ^ 32'h0001_0402, 1'b1);
    check("R8 clear plus errors", cnt, 3);
    check("R8 flag kept", st[2], 1);
    put(1'b1, gen_word(), 1'b1);
    check("R8 clear count", cnt, 0);
    check("R8 clear flag", st, 3'b000);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 33; k++) put(1'b1, ~gen_word(), 1'b0);
    check("R7 saturated", cnt, (1 << CW) - 1);
    check("R7 still locked", st[1], 0);
    put(1'b1, ~gen_word(), 1'b0);
    check("R7 no wrap", cnt, (1 << CW) - 1);
    put(1'b0, '0, 1'b1);
    check("R8 clear after saturation", cnt, 0);
  endtask

  task automatic t_inverted();
    sel = 3'd2;
    put(1'b1, 32'hDEADBEEF, 1'b1);
    check("R9 unlock on select change", st[1], 1);
    gen_init(3'd2);
    for (int k = 0; k < 4; k++) put(1'b1, ~gen_word(), 1'b0);
    check("R5 inverted status", st, 3'b001);
    check("R5 inverted count", cnt, 0);
    put(1'b1, ~(gen_word() ^ 32'h10), 1'b0);
    check("R5 error on inverted lane", cnt, 1);
    put(1'b0, '0, 1'b1);
    check("R8 polarity kept", st, 3'b001);
  endtask

  task automatic t_select_discard();
    sel = 3'd3;
    gen_init(3'd3);
    put(1'b1, gen_word(), 1'b0);
    check("R9 changed-cycle word", st[1], 1);
    gen_init(3'd3);
    for (int k = 0; k < 4; k++) put(1'b1, gen_word(), 1'b0);
    check("R9 relock", st, 3'b000);
    check("R9 count", cnt, 0);
  endtask

  task automatic t_garbage();
    sel = 3'd4;
    put(1'b0, '0, 1'b1);
    lcg = 32'h1234_5678;
    for (int k = 0; k < 20; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      put(1'b1, lcg, 1'b0);
    end
    check("R6 no lock on noise", st[1], 1);
    check("R6 no count on noise", cnt, 0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_orders();
    t_lock_timing();
    t_errors();
    t_clear_same_cycle();
    t_saturate();
    t_inverted();
    t_select_discard();
    t_garbage();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule